// File: doc/BRIEF.md
# Vectored External-Status Interrupt Controller

This block is the register and interrupt front end of a serial controller on an 8-bit processor bus. Software reaches its registers through one address: a write to register 0 sets a pointer for the next access and can also carry a command. The block samples three modem-control inputs (clear-to-send, sync and carrier detect) and reports them in status register 0. It also keeps two time-constant registers, an interrupt vector register and an external-status source-enable register, all readable.

A transition on clear-to-send can latch an external-status interrupt. When this source, the external-status interrupt and the master interrupt are all enabled and the daisy-chain input is high, the block drives an active-low interrupt request. During an acknowledge cycle it puts its vector on the data bus. It then marks itself under service and holds its daisy-chain output low, which blocks every device downstream. Two command codes then re-arm the path: one clears the latched condition and one ends the service period. Driving the read and write strobes low together resets the whole block, whatever the state of chip select.

Top module: `extstat_irq_ctrl`

## Requirements
- R1: Holding rd_n and wr_n low in the same cycle clears every register, the pending condition and the under-service flag at the next clock edge. Chip select has no effect on this. After it, int_n is high, ieo follows iei, and registers 2, 12 and 15 read 00h.
- R2: After any reset, status register 0 reads bits 7, 1 and 0 as zero and bits 6 and 2 as one, so the value masked with C7h is 44h.
- R3: With no external-status condition pending, status register 0 shows clear-to-send on bit 5, sync on bit 4 and carrier detect on bit 3. The inputs pass through two synchronizer flops and one status flop before they appear there.
- R4: In a write to register 0, bits 2:0 select the register for the next access, and bits 5:3 equal to 001 add 8 to that selection. After any read or write of the selected register the pointer goes back to 0, so the next access reaches register 0 again.
- R5: Registers 2, 12, 13 and 15 return the last value written to them. Writes to registers with no storage (for example register 3) have no effect, and such registers read 00h.
- R6: int_n goes low after a clear-to-send transition only if register 15 bit 5, register 1 bit 0 and register 9 bit 3 are all set and iei is high. With register 15 bit 5 clear, a transition raises no request.
- R7: While an external-status condition is pending, status register 0 bits 5:3 hold the values captured with the transition, whatever the inputs do.
- R8: While intack_n is low and a request is being served, dout_en is high, dout carries register 2 unchanged when register 9 bit 0 is clear, and int_n is high.
- R9: With register 9 bit 0 set, the acknowledge vector carries register 2 with bits 3:1 replaced by 101.
- R10: An accepted acknowledge sets the under-service state. That state holds ieo low and blocks further requests until command 38h is written to register 0.
- R11: Command 10h written to register 0 clears the pending condition. A later clear-to-send transition raises the request again.
- R12: With iei low the block raises no request, holds ieo low and does not answer an acknowledge. A condition that latched meanwhile raises the request once iei returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or acknowledge vector |
| dout_en | output | 1 | High while dout carries valid data |
| cts_in | input | 1 | Clear-to-send input |
| sync_in | input | 1 | Sync input |
| dcd_in | input | 1 | Carrier-detect input |
| intack_n | input | 1 | Interrupt acknowledge, active low |
| iei | input | 1 | Daisy-chain enable in |
| ieo | output | 1 | Daisy-chain enable out |
| int_n | output | 1 | Interrupt request, active low |

## Verification
On every cycle the assertions check several rules. A strobe-pair reset leaves the request released and the chain passing iei. Status register 0 keeps its fixed bits on every read. The captured status bits stay still while a condition is pending. A low iei suppresses both the request and ieo. An acknowledge answered by the block returns the stored vector and is followed by ieo going low. The pointer sequencing, register readback, the no-effect writes, vector-includes-status substitution, the re-arming command order and the exact input-to-status latency only show up in the bench's directed scenarios.

// File: rtl/extstat_pkg.sv
package extstat_pkg;
    localparam int DW    = 8;
    localparam int PTR_W = 4;

    typedef logic [DW-1:0]    byte_t;
    typedef logic [PTR_W-1:0] ptr_t;

    // register numbers reached through the pointer
    localparam ptr_t REG_CMD  = 4'd0;
    localparam ptr_t REG_IE   = 4'd1;
    localparam ptr_t REG_VEC  = 4'd2;
    localparam ptr_t REG_MCTL = 4'd9;
    localparam ptr_t REG_TCL  = 4'd12;
    localparam ptr_t REG_TCH  = 4'd13;
    localparam ptr_t REG_XIE  = 4'd15;

    // command field codes (bits 5:3 of a register 0 write)
    localparam logic [2:0] CMD_POINT_HIGH = 3'b001;
    localparam logic [2:0] CMD_RST_EXT    = 3'b010;
    localparam logic [2:0] CMD_RST_IUS    = 3'b111;

    localparam int IE_EXT_BIT  = 0;
    localparam int MIE_BIT     = 3;
    localparam int VIS_BIT     = 0;
    localparam int XIE_CTS_BIT = 5;

    localparam logic [2:0] EXT_STAT_CODE = 3'b101;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_HWRST
    } acc_e;

    typedef struct packed {
        logic cts;
        logic sync;
        logic dcd;
    } pins_t;

    typedef struct packed {
        logic ext_ie;
        logic mie;
        logic vis;
        logic cts_ie;
    } irq_cfg_t;

    typedef struct packed {
        logic rst_ext;
        logic rst_ius;
    } cmd_pulse_t;

    function automatic byte_t make_status(input pins_t p);
        return {1'b0, 1'b1, p.cts, p.sync, p.dcd, 1'b1, 1'b0, 1'b0};
    endfunction

    function automatic byte_t make_vector(input byte_t base, input logic vis);
        return vis ? {base[7:4], EXT_STAT_CODE, base[0]} : base;
    endfunction
endpackage

// File: rtl/extstat_sync.sv
module extstat_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_stage[s-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/extstat_busregs.sv
module extstat_busregs
    import extstat_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  acc_e       acc,
    input  byte_t      wdata,
    input  pins_t      status,
    output byte_t      rdata,
    output ptr_t       ptr,
    output byte_t      vec_reg,
    output irq_cfg_t   cfg,
    output cmd_pulse_t cmd
);
    byte_t tc_lo, tc_hi, xie;
    logic  is_cmd_write;

    assign is_cmd_write = (acc == ACC_WRITE) && (ptr == REG_CMD);
    assign cmd.rst_ext  = is_cmd_write && (wdata[5:3] == CMD_RST_EXT);
    assign cmd.rst_ius  = is_cmd_write && (wdata[5:3] == CMD_RST_IUS);
    assign cfg.cts_ie   = xie[XIE_CTS_BIT];

    always_ff @(posedge clk) begin
        if (clr) begin
            ptr        <= '0;
            vec_reg    <= '0;
            tc_lo      <= '0;
            tc_hi      <= '0;
            xie        <= '0;
            cfg.ext_ie <= 1'b0;
            cfg.mie    <= 1'b0;
            cfg.vis    <= 1'b0;
        end else if (acc == ACC_WRITE) begin
            if (ptr == REG_CMD) begin
                ptr <= {wdata[5:3] == CMD_POINT_HIGH, wdata[2:0]};
            end else begin
                ptr <= '0;
                case (ptr)
                    REG_IE:   cfg.ext_ie <= wdata[IE_EXT_BIT];
                    REG_VEC:  vec_reg    <= wdata;
                    REG_MCTL: begin
                        cfg.mie <= wdata[MIE_BIT];
                        cfg.vis <= wdata[VIS_BIT];
                    end
                    REG_TCL:  tc_lo <= wdata;
                    REG_TCH:  tc_hi <= wdata;
                    REG_XIE:  xie   <= wdata;
                    default:  ;
                endcase
            end
        end else if (acc == ACC_READ) begin
            ptr <= '0;
        end
    end

    always_comb begin
        case (ptr)
            REG_CMD: rdata = make_status(status);
            REG_VEC: rdata = vec_reg;
            REG_TCL: rdata = tc_lo;
            REG_TCH: rdata = tc_hi;
            REG_XIE: rdata = xie;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/extstat_irq.sv
module extstat_irq
    import extstat_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  pins_t      pins_s,
    input  irq_cfg_t   cfg,
    input  cmd_pulse_t cmd,
    input  logic       intack_n,
    input  logic       iei,
    output pins_t      status,
    output logic       ext_ip,
    output logic       ius,
    output logic       ack_drive,
    output logic       ieo,
    output logic       int_n
);
    logic req, accept, ack_hold, cts_edge;

    assign cts_edge  = !ext_ip && cfg.cts_ie && (pins_s.cts != status.cts);
    assign req       = ext_ip && cfg.ext_ie && cfg.mie && iei && !ius;
    assign accept    = !intack_n && req;
    assign int_n     = !(req && intack_n);
    assign ack_drive = !intack_n && (req || ack_hold);
    assign ieo       = iei && !ius && !req;

    always_ff @(posedge clk) begin
        if (clr) begin
            status   <= '0;
            ext_ip   <= 1'b0;
            ius      <= 1'b0;
            ack_hold <= 1'b0;
        end else begin
            if (!ext_ip) status <= pins_s;

            if (cmd.rst_ext)   ext_ip <= 1'b0;
            else if (cts_edge) ext_ip <= 1'b1;

            if (cmd.rst_ius)   ius <= 1'b0;
            else if (accept)   ius <= 1'b1;

            ack_hold <= !intack_n && (accept || ack_hold);
        end
    end
endmodule

// File: rtl/extstat_irq_ctrl.sv
module extstat_irq_ctrl
    import extstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_en,
    input  logic       cts_in,
    input  logic       sync_in,
    input  logic       dcd_in,
    input  logic       intack_n,
    input  logic       iei,
    output logic       ieo,
    output logic       int_n
);
    localparam int PIN_W = $bits(pins_t);

    acc_e       acc;
    logic       clr;
    byte_t      rdata, vec_reg;
    ptr_t       ptr;
    irq_cfg_t   cfg;
    cmd_pulse_t cmd;
    pins_t      pins_raw, pins_s, status;
    logic       ext_ip, ius, ack_drive;

    always_comb begin
        if (!rd_n && !wr_n)                 acc = ACC_HWRST;
        else if (!cs_n && !wr_n)            acc = ACC_WRITE;
        else if (!cs_n && !rd_n && intack_n) acc = ACC_READ;
        else                                acc = ACC_IDLE;
    end

    assign clr      = rst || (acc == ACC_HWRST);
    assign pins_raw = '{cts: cts_in, sync: sync_in, dcd: dcd_in};

    extstat_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    extstat_busregs u_regs (
        .clk     (clk),
        .clr     (clr),
        .acc     (acc),
        .wdata   (din),
        .status  (status),
        .rdata   (rdata),
        .ptr     (ptr),
        .vec_reg (vec_reg),
        .cfg     (cfg),
        .cmd     (cmd)
    );

    extstat_irq u_irq (
        .clk       (clk),
        .clr       (clr),
        .pins_s    (pins_s),
        .cfg       (cfg),
        .cmd       (cmd),
        .intack_n  (intack_n),
        .iei       (iei),
        .status    (status),
        .ext_ip    (ext_ip),
        .ius       (ius),
        .ack_drive (ack_drive),
        .ieo       (ieo),
        .int_n     (int_n)
    );

    assign dout    = ack_drive ? make_vector(vec_reg, cfg.vis) : rdata;
    assign dout_en = ack_drive || (acc == ACC_READ);
endmodule

// File: rtl/extstat_irq_ctrl_chk.sv
module extstat_irq_ctrl_chk
    import extstat_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [7:0] dout,
    input logic       dout_en,
    input logic       intack_n,
    input logic       iei,
    input logic       ieo,
    input logic       int_n,
    input ptr_t       ptr,
    input logic       vis,
    input byte_t      vec,
    input logic       ext_ip,
    input pins_t      status
);
    AST_HWRST_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wr_n) |=> (int_n && (ieo == iei)));                            // R1

    AST_STATUS_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && wr_n && intack_n && ptr == 4'd0)
        |-> (dout_en && dout[7:6] == 2'b01 && dout[2:0] == 3'b100));              // R2

    AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ext_ip && $past(ext_ip)) |-> $stable(status));                           // R7

    AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (!intack_n && dout_en && !vis) |-> (dout == vec && int_n));               // R8

    AST_ACK_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (!int_n ##1 (!intack_n && iei && cs_n && rd_n && wr_n)) |=> !ieo);        // R10

    AST_IEI_LOW_SILENT: assert property (@(posedge clk) disable iff (rst)
        !iei |-> (int_n && !ieo));                                                // R12
endmodule

bind extstat_irq_ctrl extstat_irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .dout     (dout),
    .dout_en  (dout_en),
    .intack_n (intack_n),
    .iei      (iei),
    .ieo      (ieo),
    .int_n    (int_n),
    .ptr      (ptr),
    .vis      (cfg.vis),
    .vec      (vec_reg),
    .ext_ip   (ext_ip),
    .status   (status)
);

// File: tb/extstat_irq_ctrl_test.sv
module extstat_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, cs_n, rd_n, wr_n, intack_n, iei;
    logic       cts_in, sync_in, dcd_in;
    logic [7:0] din, dout;
    logic       dout_en, ieo, int_n;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extstat_irq_ctrl uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .din(din), .dout(dout), .dout_en(dout_en),
        .cts_in(cts_in), .sync_in(sync_in), .dcd_in(dcd_in),
        .intack_n(intack_n), .iei(iei), .ieo(ieo), .int_n(int_n)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_raw(input logic [7:0] d);
        @(negedge clk); cs_n = 0; wr_n = 0; din = d;
        @(negedge clk); cs_n = 1; wr_n = 1;
    endtask

    function automatic logic [7:0] ptr_code(input int r);
        return (r >= 8) ? (8'h08 | 8'(r & 7)) : 8'(r);
    endfunction

    task automatic wreg(input int r, input logic [7:0] d);
        if (r != 0) wr_raw(ptr_code(r));
        wr_raw(d);
    endtask

    task automatic rreg(input int r, output logic [7:0] v);
        if (r != 0) wr_raw(ptr_code(r));
        @(negedge clk); cs_n = 0; rd_n = 0;
        #1 v = dout;
        @(negedge clk); cs_n = 1; rd_n = 1;
    endtask

    task automatic toggle_cts();
        @(negedge clk); cts_in = ~cts_in;
        wait_cyc(5);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check_eq("R2 int_n after reset", int_n, 1);
        check_eq("R2 ieo after reset", ieo, 1);
        check_eq("R2 dout_en idle", dout_en, 0);
        rreg(0, v);
        check_eq("R2 status fixed bits", v & 8'hC7, 8'h44);
    endtask

    task automatic t_pins();
        logic [7:0] v;
        logic [2:0] pats [3] = '{3'b101, 3'b010, 3'b111};
        foreach (pats[i]) begin
            @(negedge clk); {cts_in, sync_in, dcd_in} = pats[i];
            wait_cyc(5);
            rreg(0, v);
            check_eq("R3 status pins", v[5:3], pats[i]);
        end
        @(negedge clk); {cts_in, sync_in, dcd_in} = 3'b000;
        wait_cyc(5);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wreg(12, 8'hA5); wreg(13, 8'h3C); wreg(15, 8'h20); wreg(2, 8'h71);
        rreg(12, v); check_eq("R5 reg12 readback", v, 8'hA5);
        rreg(0, v);  check_eq("R4 pointer back to 0", v & 8'hC7, 8'h44);
        rreg(13, v); check_eq("R5 reg13 readback", v, 8'h3C);
        rreg(15, v); check_eq("R5 reg15 readback", v, 8'h20);
        rreg(2, v);  check_eq("R4 low pointer reg2", v, 8'h71);
        wreg(3, 8'hFF);
        rreg(3, v);  check_eq("R5 reg3 ignored", v, 8'h00);
        wreg(15, 8'h00);
        rreg(15, v); check_eq("R5 reg15 cleared", v, 8'h00);
    endtask

    task automatic t_int_enable();
        wreg(1, 8'h01); wreg(9, 8'h08);
        toggle_cts();
        check_eq("R6 no int with source disabled", int_n, 1);
        wreg(15, 8'h20);
        wait_cyc(3);
        check_eq("R6 no int without transition", int_n, 1);
        toggle_cts();
        check_eq("R6 int on cts transition", int_n, 0);
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        logic [2:0] latched;
        latched = {cts_in, sync_in, dcd_in};
        @(negedge clk); sync_in = ~sync_in; dcd_in = ~dcd_in;
        wait_cyc(5);
        rreg(0, v);
        check_eq("R7 status frozen while pending", v[5:3], latched);
        @(negedge clk); sync_in = ~sync_in; dcd_in = ~dcd_in;
        wait_cyc(5);
    endtask

    task automatic do_ack(input string req, input logic [7:0] exp_vec);
        @(negedge clk); intack_n = 0;
        #1;
        check_eq({req, " dout_en in ack"}, dout_en, 1);
        check_eq({req, " vector"}, dout, exp_vec);
        check_eq({req, " int_n high in ack"}, int_n, 1);
        @(negedge clk);
        check_eq({req, " vector held"}, dout, exp_vec);
        intack_n = 1;
        @(negedge clk);
    endtask

    task automatic t_ack();
        do_ack("R8", 8'h71);
        check_eq("R10 ieo low under service", ieo, 0);
        check_eq("R10 no request under service", int_n, 1);
        wr_raw(8'h10);
        wait_cyc(2);
        check_eq("R10 ieo still low before 38h", ieo, 0);
        wr_raw(8'h38);
        wait_cyc(1);
        check_eq("R10 ieo released by 38h", ieo, 1);
        check_eq("R11 no request after 10h", int_n, 1);
        toggle_cts();
        check_eq("R11 re-armed request", int_n, 0);
    endtask

    task automatic t_vis();
        wreg(9, 8'h09);
        do_ack("R9", 8'h7B);
        wr_raw(8'h10); wr_raw(8'h38);
        wait_cyc(1);
        check_eq("R9 clean after service", int_n, 1);
        wreg(9, 8'h08);
    endtask

    task automatic t_daisy();
        @(negedge clk); iei = 0;
        toggle_cts();
        check_eq("R12 no request with iei low", int_n, 1);
        check_eq("R12 ieo low with iei low", ieo, 0);
        @(negedge clk); intack_n = 0;
        #1 check_eq("R12 no answer to ack", dout_en, 0);
        @(negedge clk); intack_n = 1; iei = 1;
        #1 check_eq("R12 request after iei high", int_n, 0);
        wr_raw(8'h10);
        wait_cyc(1);
    endtask

    task automatic t_hwrst();
        logic [7:0] v;
        toggle_cts();
        check_eq("R1 request before strobe reset", int_n, 0);
        @(negedge clk); rd_n = 0; wr_n = 0;
        @(negedge clk); rd_n = 1; wr_n = 1;
        #1;
        check_eq("R1 int_n after strobe reset", int_n, 1);
        check_eq("R1 ieo after strobe reset", ieo, 1);
        rreg(12, v); check_eq("R1 reg12 cleared", v, 0);
        rreg(15, v); check_eq("R1 reg15 cleared", v, 0);
        rreg(2, v);  check_eq("R1 reg2 cleared", v, 0);
        rreg(0, v);  check_eq("R2 status after strobe reset", v & 8'hC7, 8'h44);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; cs_n = 1; rd_n = 1; wr_n = 1; din = '0;
        intack_n = 1; iei = 1; cts_in = 0; sync_in = 0; dcd_in = 0;
        wait_cyc(5);
        rst = 0;
        wait_cyc(2);
        t_reset_state();
        t_pins();
        t_regs();
        t_int_enable();
        t_freeze();
        t_ack();
        t_vis();
        t_daisy();
        t_hwrst();
        wait_cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule